// File: doc/BRIEF.md
# Fast Reference Loss-of-Activity Detector

This block watches the reference clock that the source selector has currently chosen. It raises a disqualify request within roughly two to three nominal reference periods after that reference stops toggling. The reference is asynchronous to the faster system clock. A chain of synchronizer flops brings it into the system-clock domain, and its rising edges are detected there. An idle counter restarts on every detected edge. When the counter reaches a programmable limit, a timeout is declared. The limit is normally set to about 2.5 reference periods, expressed in system clocks.

A timeout has an effect only while the fast-switch enable is high. In that case it sends a one-cycle disqualify pulse to the selector and sets a sticky failure flag. The flag feeds an interrupt line, which a mask can silence. A separate enable routes the flag onto the test-data output, in place of the normal test data passing through. Software clears the flag with a write-one-to-clear strobe. When the selector switches to another reference, the idle counter restarts, so that the new source gets a full window.

All pins are plain control and status signals. There is no streaming interface, so no valid/ready handshake applies.

Top module: `fast_ref_activity_monitor`

## Requirements
- R1: While reset is asserted and on the first cycle after reset, `disq_req`, `fail_flag` and `irq` are 0, and `tdo_out` equals `tdo_in` (the flag-on-test-output enable is expected low at reset).
- R2: A rising edge of `ref_in` is seen through a two-flop synchronizer plus an edge register. If `ref_in` is first sampled high at clock edge E and then stays high, the next timeout pulse is driven from clock edge E+LIMIT+3.
- R3: While detected rising edges arrive no more than LIMIT+1 cycles apart, `disq_req` stays 0.
- R4: With `fast_en` high, LIMIT+1 consecutive cycles without a detected edge after the counter restarts produce exactly one `disq_req` pulse, one cycle wide. A longer idle stretch produces no further pulse.
- R5: While `fast_en` is low, a timeout produces no `disq_req` pulse and does not set `fail_flag`.
- R6: `fail_flag` rises in the same cycle as `disq_req` and stays 1 until a cycle in which `clr_flag` is 1.
- R7: A timeout in the same cycle as `clr_flag` leaves `fail_flag` at 1, because setting takes precedence over clearing.
- R8: `irq` is 1 exactly when `fail_flag` is 1 and `irq_mask` is 0.
- R9: `tdo_out` equals `fail_flag` while `tdo_flag_en` is 1, and equals `tdo_in` otherwise.
- R10: Any change of `ref_sel` restarts the idle counter, so no timeout occurs while the selection keeps changing at intervals shorter than LIMIT+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_in | input | 1 | Selected reference clock (asynchronous) |
| ref_sel | input | SEL_W | Index of the selected reference; a change restarts the timer |
| limit | input | CNT_W | Idle limit in system clocks (LIMIT) |
| fast_en | input | 1 | Enables disqualify requests and flag setting |
| clr_flag | input | 1 | Write-one-to-clear strobe for the failure flag |
| irq_mask | input | 1 | Masks the interrupt output when 1 |
| tdo_flag_en | input | 1 | Routes the failure flag onto `tdo_out` when 1 |
| tdo_in | input | 1 | Normal test-data output to pass through |
| disq_req | output | 1 | One-cycle disqualify request to the source selector |
| fail_flag | output | 1 | Sticky main-reference-failed flag |
| irq | output | 1 | Interrupt: flag and not masked |
| tdo_out | output | 1 | Test-data output after the mux |

## Verification
A registered result becomes visible one clock edge after the inputs that cause it. This applies to `disq_req` and `fail_flag`, and to `irq` through `fail_flag`. The timeout itself trails the reference by the two synchronizer stages, the edge register and LIMIT+1 idle cycles. `tdo_out` and the mask term of `irq` follow their inputs within the same cycle. The bench changes inputs 1 ns after a rising edge and advances a behavioural model at each rising edge from the inputs present there. It then compares every output against the model at the falling edge that follows. The directed latency check for R2 counts clock edges from the first sampling edge, and the pulse is expected exactly LIMIT+3 edges later.

// File: rtl/fram_pkg.sv
package fram_pkg;
  localparam int unsigned DEF_CNT_W = 12;
  localparam int unsigned DEF_SEL_W = 3;
  localparam int unsigned DEF_SYNC  = 2;

  typedef struct packed {
    logic fast_en;
    logic irq_mask;
    logic tdo_flag_en;
  } fram_ctl_t;
endpackage

// File: rtl/fram_edge_sync.sv
module fram_edge_sync #(
  parameter int unsigned STAGES = fram_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise
);
  localparam int unsigned LAST = STAGES;

  // sh[0..STAGES-1] synchronizer, sh[STAGES] holds previous synced value
  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], ref_in};
  end

  assign rise = sh[LAST-1] & ~sh[LAST];

  // R2: a detected edge cannot repeat on the next cycle
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/fram_idle_timer.sv
module fram_idle_timer #(
  parameter int unsigned CNT_W = fram_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W = fram_pkg::DEF_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic [SEL_W-1:0] sel,
  input  logic [CNT_W-1:0] limit,
  output logic             tmo
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt;
  logic             fired;
  logic             restart;

  assign restart = rise | (sel != sel_q);
  assign tmo     = !restart && !fired && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      sel_q <= sel;
      if (restart) begin
        cnt   <= '0;
        fired <= 1'b0;
      end else if (!fired) begin
        if (cnt == limit) fired <= 1'b1;
        else              cnt   <= cnt + 1'b1;
      end
    end
  end

  // R4: one timeout per idle stretch
  a_r4_tmo_once: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);
  // R10: a selection change is followed by a fresh count
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != sel_q) |=> (cnt == '0) && !fired);
endmodule

// File: rtl/fram_fail_status.sv
module fram_fail_status (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set,
  input  logic              clr,
  input  fram_pkg::fram_ctl_t ctl,
  input  logic              tdo_in,
  output logic              flag,
  output logic              irq,
  output logic              tdo_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end

  assign irq     = flag & ~ctl.irq_mask;
  assign tdo_out = ctl.tdo_flag_en ? flag : tdo_in;

  // R6: flag only drops after a clear strobe
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(clr));
  // R7: a set always lands, even alongside a clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/fast_ref_activity_monitor.sv
module fast_ref_activity_monitor #(
  parameter int unsigned CNT_W = fram_pkg::DEF_CNT_W,
  parameter int unsigned SEL_W = fram_pkg::DEF_SEL_W,
  parameter int unsigned SYNC  = fram_pkg::DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  input  logic [SEL_W-1:0] ref_sel,
  input  logic [CNT_W-1:0] limit,
  input  logic             fast_en,
  input  logic             clr_flag,
  input  logic             irq_mask,
  input  logic             tdo_flag_en,
  input  logic             tdo_in,
  output logic             disq_req,
  output logic             fail_flag,
  output logic             irq,
  output logic             tdo_out
);
  fram_pkg::fram_ctl_t ctl;
  logic rise;
  logic tmo;
  logic hit;

  assign ctl = '{fast_en: fast_en, irq_mask: irq_mask, tdo_flag_en: tdo_flag_en};
  assign hit = tmo & ctl.fast_en;

  fram_edge_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .rise(rise)
  );

  fram_idle_timer #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .rise(rise), .sel(ref_sel),
    .limit(limit), .tmo(tmo)
  );

  fram_fail_status u_status (
    .clk(clk), .rst_n(rst_n), .set(hit), .clr(clr_flag), .ctl(ctl),
    .tdo_in(tdo_in), .flag(fail_flag), .irq(irq), .tdo_out(tdo_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disq_req <= 1'b0;
    else        disq_req <= hit;
  end

  // R4: request is a single-cycle pulse
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    disq_req |=> !disq_req);
  // R5: no request unless the fast-switch enable was high
  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    disq_req |-> $past(fast_en));
  // R6: flag accompanies every request
  a_r6_flag_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    disq_req |-> fail_flag);
endmodule

// File: tb/tb_fast_ref_activity_monitor.sv
`timescale 1ns/1ps
module tb_fast_ref_activity_monitor;
  localparam int CNT_W = 12;
  localparam int SEL_W = 3;
  localparam int LIM   = 20;
  localparam int PER   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic [SEL_W-1:0] ref_sel = '0;
  logic [CNT_W-1:0] limit = CNT_W'(LIM);
  logic fast_en = 1'b0, clr_flag = 1'b0, irq_mask = 1'b0;
  logic tdo_flag_en = 1'b0, tdo_in = 1'b0;
  logic disq_req, fail_flag, irq, tdo_out;

  always #2.5 clk = ~clk;

  fast_ref_activity_monitor #(.CNT_W(CNT_W), .SEL_W(SEL_W), .SYNC(2)) dut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .ref_sel(ref_sel),
    .limit(limit), .fast_en(fast_en), .clr_flag(clr_flag),
    .irq_mask(irq_mask), .tdo_flag_en(tdo_flag_en), .tdo_in(tdo_in),
    .disq_req(disq_req), .fail_flag(fail_flag), .irq(irq), .tdo_out(tdo_out)
  );

  int checks = 0, fails = 0, pulses = 0, phase = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: sample history queue and an idle-cycle integer
  bit hist[$] = '{0, 0, 0};
  int idle = 0, m_sel = 0;
  bit m_fired = 0, m_disq = 0, m_flag = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0}; idle = 0; m_sel = 0;
      m_fired = 0; m_disq = 0; m_flag = 0;
    end else begin
      bit edge_seen, moved, timeout;
      edge_seen = hist[1] && !hist[2];
      moved = (int'(ref_sel) != m_sel);
      timeout = !edge_seen && !moved && !m_fired && (idle == int'(limit));
      if (edge_seen || moved) begin idle = 0; m_fired = 0; end
      else if (!m_fired) begin
        if (idle == int'(limit)) m_fired = 1; else idle++;
      end
      m_flag = (timeout && fast_en) || (m_flag && !clr_flag);
      m_disq = timeout && fast_en;
      m_sel = int'(ref_sel);
      hist.push_front(ref_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (disq_req) pulses++;
    check(disq_req == m_disq, "R4 disq_req", disq_req, m_disq);
    check(fail_flag == m_flag, "R6 fail_flag", fail_flag, m_flag);
    check(irq == (m_flag && !irq_mask), "R8 irq", irq, m_flag && !irq_mask);
    check(tdo_out == (tdo_flag_en ? m_flag : tdo_in), "R9 tdo_out", tdo_out,
          tdo_flag_en ? m_flag : tdo_in);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run(input int n, input int per, input int hop);
    for (int i = 0; i < n; i++) begin
      ref_in = (per > 0) ? ((phase % per) < per / 2) : 1'b0;
      if (hop > 0 && (i % hop) == hop - 1) ref_sel = ref_sel + 1'b1;
      phase++;
      tick();
    end
  endtask

  task automatic settle();
    @(negedge clk); #0.5;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) tick();
    check(disq_req == 0 && fail_flag == 0 && irq == 0, "R1 reset outputs", fail_flag, 0);
    check(tdo_out == tdo_in, "R1 reset tdo", tdo_out, tdo_in);
    rst_n = 1'b1;
    tick();
    check(disq_req == 0 && fail_flag == 0, "R1 after reset", fail_flag, 0);
    fast_en = 1'b1;

    pulses = 0; run(200, PER, 0); settle();
    check(pulses == 0, "R3 steady activity", pulses, 0);

    pulses = 0; run(60, 0, 0); settle();
    check(pulses == 1, "R4 single pulse", pulses, 1);
    check(fail_flag == 1, "R6 flag set", fail_flag, 1);
    pulses = 0; run(50, 0, 0); settle();
    check(pulses == 0 && fail_flag == 1, "R6 flag held, no repeat R4", pulses, 0);

    irq_mask = 1'b1; tick();
    check(irq == 0, "R8 masked", irq, 0);
    irq_mask = 1'b0; tick();
    check(irq == 1, "R8 unmasked", irq, 1);

    tdo_flag_en = 1'b1; tdo_in = 1'b0; tick();
    check(tdo_out == 1, "R9 flag on tdo", tdo_out, 1);
    clr_flag = 1'b1; tick(); clr_flag = 1'b0; tick();
    check(fail_flag == 0 && tdo_out == 0, "R6 cleared, R9 follows", fail_flag, 0);
    tdo_flag_en = 1'b0; tdo_in = 1'b1; tick();
    check(tdo_out == 1, "R9 pass-through", tdo_out, 1);

    // R2 latency: one rising edge, then hold high
    begin
      int first = -1;
      ref_in = 1'b1;
      for (int t = 1; t <= LIM + 10; t++) begin
        tick();
        if (disq_req && first < 0) first = t;
      end
      check(first == LIM + 4, "R2 edge-to-timeout latency", first, LIM + 4);
    end
    clr_flag = 1'b1; tick(); clr_flag = 1'b0;

    // R7: clear held through the timeout cycle
    run(40, PER, 0);
    clr_flag = 1'b1;
    begin
      bit seen = 0;
      for (int t = 0; t < 40; t++) begin
        ref_in = 1'b0; tick();
        if (disq_req) begin
          seen = 1;
          check(fail_flag == 1, "R7 set beats clear", fail_flag, 1);
        end
      end
      check(seen, "R7 timeout occurred", seen, 1);
    end
    clr_flag = 1'b0; tick();
    check(fail_flag == 0, "R7 cleared after", fail_flag, 0);

    fast_en = 1'b0;
    pulses = 0; run(40, PER, 0); run(60, 0, 0); settle();
    check(pulses == 0 && fail_flag == 0, "R5 disabled", pulses, 0);

    fast_en = 1'b1;
    run(40, PER, 0);
    pulses = 0; run(100, 0, 10); settle();
    check(pulses == 0, "R10 selection hopping", pulses, 0);
    pulses = 0; run(40, 0, 0); settle();
    check(pulses == 1, "R10 timeout after hopping", pulses, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule